// File: doc/BRIEF.md
# Serial Key Checksum Engine

This block condenses a 128-bit key into an 8-bit checksum so that software can confirm that the right key was loaded without ever reading the key itself back. The key is treated as four 32-bit words. Before it is used, each word is XOR-whitened. Word 0 gets a fixed pattern. Each later word gets a pattern built from a per-word strobe constant and the checksum left by the word before it. The whitened word then runs one bit per clock through an 8-bit CRC register, and the register is folded with a constant once the word's last bit has been shifted in.

A single-cycle start pulse, taken only while the engine is idle, launches a computation. Busy stays high until the final word has been folded. At that point done pulses for one cycle, and the result stays on its output until the next accepted start. The key input must not change while busy is high. The engine samples each word from the port at the time that word is loaded, so it holds no copy of the key.

Top module: `ksum_engine`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0 and result_o is 0x00.
- R2: A start_i pulse sampled while idle is accepted: busy_o is 1 from the next clock edge onward.
- R3: Word j of the key is key_i[32*j+31 : 32*j]. Word 0 is XORed with 0xAA55AA55 before it is processed.
- R4: Words 1, 2 and 3 are XORed with the 32-bit pattern {s, c, s, c} (bytes from most to least significant). Here c is the checksum left after the previous word, and s is 0x03 for word 1, 0x18 for word 2 and 0xC0 for word 3.
- R5: The 8-bit CRC register is cleared before each word. The 32 whitened bits enter most significant bit first. For each bit, the feedback is register bit 7 XOR the key bit, the register shifts left by one, and it is XORed with 0x07 when the feedback is 1.
- R6: After the 32nd bit of every word, the register is XORed with 0x55. The value after word 3 is the result.
- R7: done_o rises at the 132nd clock edge after the edge that accepted start (128 shift cycles plus one load cycle per word). busy_o stays 1 until that edge.
- R8: done_o lasts exactly one cycle and is never 1 while busy_o is 1. result_o does not change while the engine is idle.
- R9: A start_i pulse sampled while busy_o is 1 is ignored: the running computation ends at its original time with its original result, and no new computation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, accepted only when idle |
| key_i | input | 128 | Key, four 32-bit words; must be stable while busy |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse when result_o becomes valid |
| result_o | output | 8 | 8-bit key checksum |

## Verification
Two events can land on the same clock edge: the sequencer finishing its last shift, and a new start request. The bench raises start so that it is sampled at the final busy edge, and checks that this request is dropped (busy stays low afterwards). It also raises start in the cycle where done is high and busy has just fallen, and checks that this request launches a new run with the usual latency and a correct checksum. Start pulses in the middle of a run are checked against the unchanged finish time and result. The expected values come from a bench model of the whitening and CRC rules, applied to random keys and to directed keys.

// File: rtl/ksum_pkg.sv
package ksum_pkg;

  localparam int unsigned KS_CRC_W = 8;
  localparam logic [KS_CRC_W-1:0] KS_POLY     = 8'h07;
  localparam logic [KS_CRC_W-1:0] KS_FOLD     = 8'h55;
  localparam logic [15:0]         KS_SEED_PAT = 16'hAA55;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } ks_state_e;

  // strobe byte mixed into every word after the first
  function automatic logic [KS_CRC_W-1:0] ks_strobe(input int unsigned idx);
    case (idx)
      1:       ks_strobe = 8'h03;
      2:       ks_strobe = 8'h18;
      3:       ks_strobe = 8'hC0;
      default: ks_strobe = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ks_rst_sync.sv
module ks_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ks_seq.sv
module ks_seq
  import ksum_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
  localparam int unsigned BIT_W    = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             last_bit_o,
  output logic [IDX_W-1:0] word_idx_o
);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NUM_WORDS - 1);

  ks_state_e        state_q, state_d;
  logic [IDX_W-1:0] word_q, word_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LOAD;
          word_d  = '0;
        end
      end
      ST_LOAD: begin
        state_d = ST_SHIFT;
        bit_d   = '0;
      end
      ST_SHIFT: begin
        bit_d = bit_q + 1'b1;
        if (bit_q == LAST_BIT) begin
          if (word_q == LAST_WORD) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            word_d  = word_q + 1'b1;
            state_d = ST_LOAD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign load_o     = (state_q == ST_LOAD);
  assign shift_o    = (state_q == ST_SHIFT);
  assign last_bit_o = shift_o && (bit_q == LAST_BIT);
  assign word_idx_o = word_q;
endmodule

// File: rtl/ks_whiten.sv
module ks_whiten
  import ksum_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
  localparam int unsigned KEY_W    = NUM_WORDS * WORD_W,
  localparam int unsigned LANES    = WORD_W / KS_CRC_W
) (
  input  logic [KEY_W-1:0]    key_i,
  input  logic [IDX_W-1:0]    word_idx_i,
  input  logic [KS_CRC_W-1:0] crc_prev_i,
  output logic [WORD_W-1:0]   word_o
);
  logic [WORD_W-1:0]   raw_word;
  logic [WORD_W-1:0]   chain_mask;
  logic [WORD_W-1:0]   seed_mask;
  logic [KS_CRC_W-1:0] strobe;

  assign raw_word  = key_i[word_idx_i*WORD_W +: WORD_W];
  assign strobe    = ks_strobe(int'(word_idx_i));
  assign seed_mask = {(WORD_W/16){KS_SEED_PAT}};

  // odd byte lanes carry the strobe, even lanes the running checksum
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g % 2 == 1) begin : g_strobe
      assign chain_mask[g*KS_CRC_W +: KS_CRC_W] = strobe;
    end else begin : g_chain
      assign chain_mask[g*KS_CRC_W +: KS_CRC_W] = crc_prev_i;
    end
  end

  assign word_o = raw_word ^ ((word_idx_i == '0) ? seed_mask : chain_mask);
endmodule

// File: rtl/ks_crc_core.sv
module ks_crc_core
  import ksum_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic                last_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [KS_CRC_W-1:0] crc_o
);
  logic [WORD_W-1:0]   sh_q, sh_d;
  logic [KS_CRC_W-1:0] crc_q, crc_d;
  logic [KS_CRC_W-1:0] stepped;
  logic                fb;

  assign fb      = crc_q[KS_CRC_W-1] ^ sh_q[WORD_W-1];
  assign stepped = {crc_q[KS_CRC_W-2:0], 1'b0} ^ (fb ? KS_POLY : '0);

  always_comb begin
    sh_d  = sh_q;
    crc_d = crc_q;
    if (load_i) begin
      sh_d  = word_i;
      crc_d = '0;
    end else if (shift_i) begin
      sh_d  = {sh_q[WORD_W-2:0], 1'b0};
      crc_d = last_i ? (stepped ^ KS_FOLD) : stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      crc_q <= '0;
    end else if (load_i || shift_i) begin
      sh_q  <= sh_d;
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/ksum_engine.sv
module ksum_engine
  import ksum_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
  localparam int unsigned KEY_W    = NUM_WORDS * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [KEY_W-1:0]    key_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [KS_CRC_W-1:0] result_o
);
  logic             rst_core_n;
  logic             load, shift, last_bit;
  logic [IDX_W-1:0] word_idx;
  logic [WORD_W-1:0] white_word;
  logic [KS_CRC_W-1:0] crc;

  ks_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ks_seq #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .load_o     (load),
    .shift_o    (shift),
    .last_bit_o (last_bit),
    .word_idx_o (word_idx)
  );

  ks_whiten #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_whiten (
    .key_i      (key_i),
    .word_idx_i (word_idx),
    .crc_prev_i (crc),
    .word_o     (white_word)
  );

  ks_crc_core #(.WORD_W(WORD_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_i  (load),
    .shift_i (shift),
    .last_i  (last_bit),
    .word_i  (white_word),
    .crc_o   (crc)
  );

  assign result_o = crc;
endmodule

// File: rtl/ksum_engine_chk.sv
module ksum_engine_chk #(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] result_o
);
  localparam int unsigned RUN_CYC = NUM_WORDS * (WORD_W + 1);
  localparam int unsigned CNT_W   = $clog2(RUN_CYC + 2) + 1;

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_cnt == CNT_W'(RUN_CYC)));

  p_end_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(result_o));
endmodule

bind ksum_engine ksum_engine_chk #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/ksum_engine_test.sv
module ksum_engine_test;
  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [127:0] key_i;
  logic         busy_o;
  logic         done_o;
  logic [7:0]   result_o;

  int applied = 0;
  int fails   = 0;

  ksum_engine uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .key_i    (key_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] strobe_of(input int j);
    case (j)
      1: return 8'h03;
      2: return 8'h18;
      3: return 8'hC0;
      default: return 8'h00;
    endcase
  endfunction

  // model of R3..R6
  function automatic logic [7:0] ref_sum(input logic [127:0] k);
    logic [7:0]  c;
    logic [7:0]  prev;
    logic [31:0] w;
    logic        fb;
    prev = 8'h00;
    c    = 8'h00;
    for (int j = 0; j < 4; j++) begin
      w = k[32*j +: 32];
      if (j == 0) w = w ^ 32'hAA55AA55;
      else        w = w ^ {strobe_of(j), prev, strobe_of(j), prev};
      c = 8'h00;
      for (int i = 31; i >= 0; i--) begin
        fb = c[7] ^ w[i];
        c  = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
      c    = c ^ 8'h55;
      prev = c;
    end
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive start at a negedge; return latency in edges and result
  // mid_at > 0: pulse a stray start at that latency count (R9)
  task automatic run_one(input logic [127:0] k, input int mid_at,
                         output int lat, output logic [7:0] res);
    key_i   = k;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", int'(busy_o), 1);
    lat = 0;
    while (!done_o && lat < 400) begin
      @(negedge clk);
      lat++;
      start_i = (mid_at > 0 && lat == mid_at);
    end
    start_i = 1'b0;
    res = result_o;
  endtask

  initial begin
    int          lat;
    logic [7:0]  res;
    logic [127:0] k;
    void'($urandom(32'h5EED1234));
    rst_n   = 1'b0;
    start_i = 1'b0;
    key_i   = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 result", int'(result_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 result after release", int'(result_o), 0);

    // directed keys (R3 R4 R5 R6)
    run_one(128'h0, 0, lat, res);
    chk("R7 latency zero key", lat, 132);
    chk("R6 zero key", int'(res), int'(ref_sum(128'h0)));
    @(negedge clk);
    chk("R8 done single", int'(done_o), 0);
    run_one({128{1'b1}}, 0, lat, res);
    chk("R5 ones key", int'(res), int'(ref_sum({128{1'b1}})));
    run_one(128'h1, 0, lat, res);
    chk("R3 word0 lsb", int'(res), int'(ref_sum(128'h1)));
    run_one(128'h1 << 127, 0, lat, res);
    chk("R4 word3 msb", int'(res), int'(ref_sum(128'h1 << 127)));
    run_one({96'h0, 32'hAA55AA55}, 0, lat, res);
    chk("R3 seed cancel", int'(res), int'(ref_sum({96'h0, 32'hAA55AA55})));

    // R8 result held while idle
    res = result_o;
    repeat (7) @(negedge clk);
    chk("R8 result hold", int'(result_o), int'(res));

    // R9 stray start mid-run
    k = {$urandom, $urandom, $urandom, $urandom};
    run_one(k, 50, lat, res);
    chk("R9 latency with stray start", lat, 132);
    chk("R9 result with stray start", int'(res), int'(ref_sum(k)));

    // R9 start sampled at the last busy edge is dropped
    k = {$urandom, $urandom, $urandom, $urandom};
    run_one(k, 131, lat, res);
    chk("R9 last-edge latency", lat, 132);
    chk("R9 last-edge result", int'(res), int'(ref_sum(k)));
    @(negedge clk);
    chk("R9 no restart", int'(busy_o), 0);

    // R2/R7 start in the done cycle is accepted
    k = {$urandom, $urandom, $urandom, $urandom};
    run_one(k, 0, lat, res);
    k = {$urandom, $urandom, $urandom, $urandom};
    run_one(k, 0, lat, res);
    chk("R7 back-to-back latency", lat, 132);
    chk("R6 back-to-back result", int'(res), int'(ref_sum(k)));

    // random keys
    for (int n = 0; n < 24; n++) begin
      k = {$urandom, $urandom, $urandom, $urandom};
      run_one(k, 0, lat, res);
      chk("R7 random latency", lat, 132);
      chk("R6 random result", int'(res), int'(ref_sum(k)));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule